// File: doc/BRIEF.md
# Reset and Power-State Controller

This block ranks three active-low reset sources and tracks the power state of the system around it. A power-on reset outranks the rest: it clears every storage element and sets a cold-start flag. A power-fail input and a user reset, together with the power-on reset, form the system reset. That reset is asserted asynchronously and released through a two-stage synchronizer on the system clock.

Once out of reset, the block always starts in Standby. Wake, idle, interrupt and sleep requests move it between four states: Operating, Idle, Snooze and Standby. The state sets a standby/RUN pair and one enable line per peripheral. Snooze keeps the display and DC-DC interfaces running while the main clock is stopped. The real-time clock enable is never gated.

A status register records which resets have occurred. Writing 1 to a bit clears that bit.

Top module: `rpc_reset_power_ctrl`

## Requirements
- R1: While `por_n_i` is low, `sys_rst_n_o`, `stby_n_o` and `run_o` are low and `status_o` reads 16'h8000: bit 15 is the cold-start flag and is set, and every other bit is cleared.
- R2: `sys_rst_n_o` goes low without waiting for a clock edge whenever any of `por_n_i`, `pwrfail_n_i` or `ureset_n_i` is low. The power state is forced to Standby at the same time.
- R3: After all three sources are high, `sys_rst_n_o` stays low through the first rising clock edge and goes high on the second. The block then sits in Standby.
- R4: A low `pwrfail_n_i` sampled at a clock edge sets status bit 0, and a low `ureset_n_i` sets status bit 1. Neither changes bit 15, and neither of these bits is cleared by any reset except power-on.
- R5: When `stat_wr_i` is high, each status bit whose `stat_wdata_i` bit is 1 is cleared on that edge. Bits written with 0 are unchanged.
- R6: In Standby or Snooze, `wake_i` moves the state to Operating on the next edge. Wake has no effect in Idle.
- R7: In Operating, `idle_req_i` moves the state to Idle. In Idle, `irq_i` returns it to Operating. Idle and sleep requests are ignored in Idle and Standby.
- R8: In Operating, `sleep_req_i` moves the state to Snooze when `sleep_mode_i` is 1 and to Standby when it is 0. A sleep request wins over a simultaneous idle request.
- R9: `stby_n_o` and `run_o` are high in Operating and Idle and low in Snooze, Standby and reset. They change on the same edge as the state.
- R10: `periph_en_o` bit map: 0 UART0, 1 UART1, 2 IrDA encoder, 3 timers, 4 codec, 5 SSI0, 6 SSI1, 7 LCD, 8 DC-DC, 9 PWM, 10 RTC. In Operating and Idle, all 11 bits are 1.
- R11: In Snooze, only bits 7, 8 and 10 are 1 (11'h580). In Standby and during reset, only bit 10 is 1 (11'h400). Whenever `stby_n_o` is low, bits 0 to 6 are 0.
- R12: The RTC enable (bit 10) is 1 in every state, including every reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_n_i | input | 1 | Power-on reset, active low, highest priority |
| pwrfail_n_i | input | 1 | Power-fail reset, active low |
| ureset_n_i | input | 1 | User reset, active low |
| wake_i | input | 1 | Wake request (Standby/Snooze to Operating) |
| idle_req_i | input | 1 | Idle request (Operating to Idle) |
| irq_i | input | 1 | Interrupt (Idle to Operating) |
| sleep_req_i | input | 1 | Sleep request from Operating |
| sleep_mode_i | input | 1 | 1 selects Snooze, 0 selects Standby |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 16 | Write-1-to-clear mask |
| sys_rst_n_o | output | 1 | System reset, active low |
| stby_n_o | output | 1 | Standby strobe, high when the main clock runs |
| run_o | output | 1 | Run indicator |
| periph_en_o | output | 11 | Per-peripheral enables |
| status_o | output | 16 | Reset status flags |

## Verification
The bench builds the block with its default parameters: a two-stage release synchronizer and a 16-bit status word. With two stages, the bench can check the exact edge on which reset releases. With 16 bits, the cold-start flag sits at bit 15 and the bench can write that bit directly. The stimulus walks every state transition, including a simultaneous sleep and idle request and requests that must be ignored. Each reset source is asserted mid-run and checked at the ports before the next clock edge. The bench also checks which flags survive each kind of reset.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  typedef enum logic [1:0] {
    PS_STANDBY = 2'd0,
    PS_OPER    = 2'd1,
    PS_IDLE    = 2'd2,
    PS_SNOOZE  = 2'd3
  } pwr_state_t;

  localparam int PE_UART0 = 0;
  localparam int PE_UART1 = 1;
  localparam int PE_IRDA  = 2;
  localparam int PE_TIMER = 3;
  localparam int PE_CODEC = 4;
  localparam int PE_SSI0  = 5;
  localparam int PE_SSI1  = 6;
  localparam int PE_LCD   = 7;
  localparam int PE_DCDC  = 8;
  localparam int PE_PWM   = 9;
  localparam int PE_RTC   = 10;
  localparam int N_PERIPH = 11;

  // peripherals always stopped when the main clock is stopped
  localparam logic [N_PERIPH-1:0] MAIN_ONLY_MASK =
    N_PERIPH'((1 << (PE_SSI1 + 1)) - 1);
  // peripherals kept alive in Snooze
  localparam logic [N_PERIPH-1:0] SNOOZE_KEEP_MASK =
    N_PERIPH'((1 << PE_LCD) | (1 << PE_DCDC));
  localparam logic [N_PERIPH-1:0] ALL_MASK = '1;

endpackage

// File: rtl/rpc_reset_sync.sv
module rpc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];

  // R2: a low source keeps the synchronized reset low
  a_r2_hold_low: assert property (@(posedge clk_i)
    !arst_n_i |-> !rst_n_o);

  // R3: release only after the source was high on the previous edge
  a_r3_release_after_high: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    $rose(rst_n_o) |-> $past(arst_n_i));

endmodule

// File: rtl/rpc_power_fsm.sv
module rpc_power_fsm
  import rpc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       wake_i,
  input  logic       idle_req_i,
  input  logic       irq_i,
  input  logic       sleep_req_i,
  input  logic       sleep_mode_i,
  output pwr_state_t state_o,
  output pwr_state_t state_nxt_o,
  output logic       awake_o
);

  pwr_state_t state_q, state_d;
  logic       awake_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_STANDBY: if (wake_i) state_d = PS_OPER;
      PS_SNOOZE:  if (wake_i) state_d = PS_OPER;
      PS_IDLE:    if (irq_i)  state_d = PS_OPER;
      PS_OPER: begin
        if (sleep_req_i)     state_d = sleep_mode_i ? PS_SNOOZE : PS_STANDBY;
        else if (idle_req_i) state_d = PS_IDLE;
      end
      default: state_d = PS_STANDBY;
    endcase
  end

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      state_q <= PS_STANDBY;
      awake_q <= 1'b0;
    end else begin
      state_q <= state_d;
      awake_q <= (state_d == PS_OPER) || (state_d == PS_IDLE);
    end
  end

  assign state_o     = state_q;
  assign state_nxt_o = state_d;
  assign awake_o     = awake_q;

  // R2: leaving reset always starts in Standby
  a_r2_exit_standby: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> (state_q == PS_STANDBY));

  // R6: wake from Standby
  a_r6_wake: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == PS_STANDBY && wake_i) |=> (state_q == PS_OPER));

  // R7: interrupt leaves Idle
  a_r7_irq_exit: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == PS_IDLE && irq_i) |=> (state_q == PS_OPER));

  // R8: sleep beats idle request
  a_r8_sleep_prio: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == PS_OPER && sleep_req_i && sleep_mode_i) |=> (state_q == PS_SNOOZE));

endmodule

// File: rtl/rpc_periph_gate.sv
module rpc_periph_gate
  import rpc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_i,
  input  pwr_state_t          state_nxt_i,
  output logic [N_PERIPH-1:0] en_o
);

  logic [N_PERIPH-1:0] en_d, en_q;

  always_comb begin
    unique case (state_nxt_i)
      PS_OPER, PS_IDLE: en_d = ALL_MASK;
      PS_SNOOZE:        en_d = SNOOZE_KEEP_MASK;
      default:          en_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) en_q <= '0;
    else       en_q <= en_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_PERIPH; gi++) begin : g_en
      if (gi == PE_RTC) begin : g_free
        assign en_o[gi] = 1'b1;
      end else begin : g_gated
        assign en_o[gi] = en_q[gi];
      end
    end
  endgenerate

endmodule

// File: rtl/rpc_status_reg.sv
module rpc_status_reg #(
  parameter int STAT_W = 16
) (
  input  logic              clk_i,
  input  logic              por_n_i,
  input  logic              pwrfail_n_i,
  input  logic              ureset_n_i,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] stat_o
);

  localparam int COLD_BIT = STAT_W - 1;
  localparam int PF_BIT   = 0;
  localparam int UR_BIT   = 1;
  localparam logic [STAT_W-1:0] COLD_INIT = STAT_W'(1) << COLD_BIT;

  logic [STAT_W-1:0] stat_q, set_v, clr_v;

  always_comb begin
    set_v         = '0;
    set_v[PF_BIT] = !pwrfail_n_i;
    set_v[UR_BIT] = !ureset_n_i;
    clr_v         = wr_i ? wdata_i : '0;
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) stat_q <= COLD_INIT;
    else          stat_q <= (stat_q & ~clr_v) | set_v;
  end

  assign stat_o = stat_q;

  // R1: power-on reset leaves only the cold-start flag
  a_r1_por_status: assert property (@(posedge clk_i)
    !por_n_i |-> (stat_o == COLD_INIT));

  // R4: power-fail sets its flag
  a_r4_pf_flag: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !pwrfail_n_i |=> stat_o[PF_BIT]);

  // R4 R5: cold flag only moves by a write of 1
  a_r5_cold_keep: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !(wr_i && wdata_i[COLD_BIT]) |=> $stable(stat_o[COLD_BIT]));

endmodule

// File: rtl/rpc_reset_power_ctrl.sv
module rpc_reset_power_ctrl
  import rpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STAT_W      = 16
) (
  input  logic                clk_i,
  input  logic                por_n_i,
  input  logic                pwrfail_n_i,
  input  logic                ureset_n_i,
  input  logic                wake_i,
  input  logic                idle_req_i,
  input  logic                irq_i,
  input  logic                sleep_req_i,
  input  logic                sleep_mode_i,
  input  logic                stat_wr_i,
  input  logic [STAT_W-1:0]   stat_wdata_i,
  output logic                sys_rst_n_o,
  output logic                stby_n_o,
  output logic                run_o,
  output logic [N_PERIPH-1:0] periph_en_o,
  output logic [STAT_W-1:0]   status_o
);

  logic       src_ok_n;
  logic       rst_n_sync;
  logic       sys_rst;
  logic       awake;
  pwr_state_t state, state_nxt;

  assign src_ok_n = por_n_i & pwrfail_n_i & ureset_n_i;

  rpc_reset_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .arst_n_i (src_ok_n),
    .rst_n_o  (rst_n_sync)
  );

  assign sys_rst = !rst_n_sync;

  rpc_power_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_i        (sys_rst),
    .wake_i       (wake_i),
    .idle_req_i   (idle_req_i),
    .irq_i        (irq_i),
    .sleep_req_i  (sleep_req_i),
    .sleep_mode_i (sleep_mode_i),
    .state_o      (state),
    .state_nxt_o  (state_nxt),
    .awake_o      (awake)
  );

  rpc_periph_gate u_gate (
    .clk_i       (clk_i),
    .rst_i       (sys_rst),
    .state_nxt_i (state_nxt),
    .en_o        (periph_en_o)
  );

  rpc_status_reg #(.STAT_W(STAT_W)) u_stat (
    .clk_i       (clk_i),
    .por_n_i     (por_n_i),
    .pwrfail_n_i (pwrfail_n_i),
    .ureset_n_i  (ureset_n_i),
    .wr_i        (stat_wr_i),
    .wdata_i     (stat_wdata_i),
    .stat_o      (status_o)
  );

  assign sys_rst_n_o = rst_n_sync;
  assign stby_n_o    = awake;
  assign run_o       = awake;

  // R1: power-on reset forces system reset and standby
  a_r1_por_forces: assert property (@(posedge clk_i)
    !por_n_i |-> (!sys_rst_n_o && !stby_n_o && !run_o));

  // R11: main-clock peripherals are off whenever standby is active
  a_r11_main_off: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !stby_n_o |-> ((periph_en_o & MAIN_ONLY_MASK) == '0));

  // R9: awake outputs agree with the recorded state
  a_r9_awake_state: assert property (@(posedge clk_i) disable iff (sys_rst)
    stby_n_o == (state == PS_OPER || state == PS_IDLE));

  // R12: the RTC enable stays on
  a_r12_rtc_on: assert property (@(posedge clk_i)
    !sys_rst_n_o |-> periph_en_o[PE_RTC]);

endmodule

// File: tb/rpc_reset_power_ctrl_bench.sv
module rpc_reset_power_ctrl_bench;

  localparam int W = 30;

  logic        clk = 1'b0;
  logic        por_n = 1'b1, pf_n = 1'b1, ur_n = 1'b1;
  logic        wake = 1'b0, idle_req = 1'b0, irq = 1'b0;
  logic        sleep_req = 1'b0, sleep_mode = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic        sys_rst_n, stby_n, run;
  logic [10:0] en;
  logic [15:0] stat;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    string          req;
    logic [W-1:0]   exp;
  } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  rpc_reset_power_ctrl u_rpc_reset_power_ctrl (
    .clk_i        (clk),
    .por_n_i      (por_n),
    .pwrfail_n_i  (pf_n),
    .ureset_n_i   (ur_n),
    .wake_i       (wake),
    .idle_req_i   (idle_req),
    .irq_i        (irq),
    .sleep_req_i  (sleep_req),
    .sleep_mode_i (sleep_mode),
    .stat_wr_i    (wr),
    .stat_wdata_i (wdata),
    .sys_rst_n_o  (sys_rst_n),
    .stby_n_o     (stby_n),
    .run_o        (run),
    .periph_en_o  (en),
    .status_o     (stat)
  );

  // mode: 0 reset, 1 standby, 2 operating/idle, 3 snooze
  function automatic logic [W-1:0] model(input int mode, input logic [15:0] st);
    logic        rn, aw;
    logic [10:0] e;
    rn = (mode != 0);
    aw = (mode == 2);
    e  = (mode == 2) ? 11'h7FF : (mode == 3) ? 11'h580 : 11'h400;
    return {rn, aw, aw, e, st};
  endfunction

  function automatic logic [W-1:0] observe();
    return {sys_rst_n, stby_n, run, en, stat};
  endfunction

  task automatic compare(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver side: expected result after the next rising edge
  task automatic expect_edge(input string req, input int mode, input logic [15:0] st);
    item_t it;
    @(posedge clk);
    #1;
    it.req = req;
    it.exp = model(mode, st);
    exp_q.push_back(it);
  endtask

  task automatic check_now(input string req, input int mode, input logic [15:0] st);
    compare(req, observe(), model(mode, st));
  endtask

  // monitor: pops and compares after each edge
  always @(posedge clk) begin
    #2;
    while (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      compare(it.req, observe(), it.exp);
    end
  end

  initial begin
    #1 por_n = 1'b0;
    expect_edge("R1 por state", 0, 16'h8000);
    expect_edge("R1 R12 por held", 0, 16'h8000);
    @(negedge clk) por_n = 1'b1;
    expect_edge("R3 first edge still reset", 0, 16'h8000);
    expect_edge("R3 R11 released standby", 1, 16'h8000);
    @(negedge clk) wake = 1'b1;
    expect_edge("R6 R9 R10 wake to operating", 2, 16'h8000);
    @(negedge clk) begin wake = 1'b0; idle_req = 1'b1; end
    expect_edge("R7 idle entry", 2, 16'h8000);
    @(negedge clk) begin idle_req = 1'b0; wake = 1'b1; end
    expect_edge("R6 wake ignored in idle", 2, 16'h8000);
    @(negedge clk) begin wake = 1'b0; sleep_req = 1'b1; sleep_mode = 1'b1; end
    expect_edge("R7 sleep ignored in idle", 2, 16'h8000);
    @(negedge clk) begin sleep_req = 1'b0; irq = 1'b1; end
    expect_edge("R7 irq to operating", 2, 16'h8000);
    @(negedge clk) begin irq = 1'b0; sleep_req = 1'b1; idle_req = 1'b1; end
    expect_edge("R8 R11 sleep beats idle to snooze", 3, 16'h8000);
    @(negedge clk) begin sleep_req = 1'b0; idle_req = 1'b0; end
    expect_edge("R8 snooze holds", 3, 16'h8000);
    @(negedge clk) wake = 1'b1;
    expect_edge("R6 wake from snooze", 2, 16'h8000);
    @(negedge clk) begin wake = 1'b0; sleep_req = 1'b1; sleep_mode = 1'b0; end
    expect_edge("R8 R9 R11 sleep to standby", 1, 16'h8000);
    @(negedge clk) begin sleep_req = 1'b0; idle_req = 1'b1; end
    expect_edge("R7 idle ignored in standby", 1, 16'h8000);
    @(negedge clk) begin idle_req = 1'b0; wake = 1'b1; end
    expect_edge("R6 wake again", 2, 16'h8000);

    @(negedge clk) begin wake = 1'b0; ur_n = 1'b0; end
    #1 check_now("R2 user reset async", 0, 16'h8000);
    expect_edge("R4 user flag set cold kept", 0, 16'h8002);
    @(negedge clk) ur_n = 1'b1;
    expect_edge("R3 user release first edge", 0, 16'h8002);
    expect_edge("R3 user release standby", 1, 16'h8002);

    @(negedge clk) begin wr = 1'b1; wdata = 16'h0000; end
    expect_edge("R5 zero write no effect", 1, 16'h8002);
    @(negedge clk) wdata = 16'h8000;
    expect_edge("R5 clear cold flag", 1, 16'h0002);
    @(negedge clk) wdata = 16'h0002;
    expect_edge("R5 clear user flag", 1, 16'h0000);
    @(negedge clk) begin wr = 1'b0; wdata = 16'h0000; end

    @(negedge clk) pf_n = 1'b0;
    #1 check_now("R2 power-fail async", 0, 16'h0000);
    expect_edge("R4 pf flag cold untouched", 0, 16'h0001);
    @(negedge clk) pf_n = 1'b1;
    expect_edge("R3 pf release first edge", 0, 16'h0001);
    expect_edge("R3 pf release standby", 1, 16'h0001);

    @(negedge clk) por_n = 1'b0;
    #1 check_now("R1 por async sets cold clears rest", 0, 16'h8000);
    expect_edge("R1 R12 por again", 0, 16'h8000);
    @(negedge clk) por_n = 1'b1;
    repeat (3) @(posedge clk);
    #4;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule